// File: doc/BRIEF.md
# Indirect Stream Address Generator

This block turns a list of element ids into memory transaction descriptors. Software loads a filter value, sets the control fields and pulses start. The block then takes ids one at a time from a ready/valid stream and returns the word address each id was fetched from. For every id that is not filtered it issues one descriptor on a ready/valid output. A descriptor carries a source/destination address in the table and a write address in the destination tile. The table address is the table base plus an offset plus either the raw id (word mode) or the id scaled by a 4-bit row stride (row mode).

The offset is either a fixed scalar operand or the current position of a circular window. The window position steps by one per id and wraps at the window size. The destination pointer steps by a power-of-two granule chosen by a 3-bit code, or stays put for code 7. It can wrap inside a circular destination buffer. A completion counter counts either 4-byte words or descriptors. An optional done flag rises when the whole list has been consumed and every descriptor has been handed off. Data movement and the add arithmetic are left to the consumer of the descriptors.

Top module: `idx_stream_agu`

## Requirements
- R1: With list type 0 (word), the table address is table_base + offset + id, where offset is ofs_static when offset source is 0.
- R2: With list type 1 (row), the table address is table_base + offset + id * row_stride, with row_stride 4 bits wide.
- R3: The destination address is dst_base plus a pointer that starts at 0 and steps by 32 << code bytes per advancing id for codes 0..6. Code 7 leaves the pointer unchanged.
- R4: With filtering on and filter mode 0 (skip), an id equal to the active filter value produces no descriptor, but the destination pointer still advances.
- R5: With filtering on and filter mode 1 (compact), a matching id produces no descriptor and does not advance the destination pointer.
- R6: With offset source 1 (window), the offset for each id is the window position. The position starts at win_offset and, when win_post_upd is 1, steps by one per accepted id (filtered or not), wrapping to 0 at win_size.
- R7: cmpl_count is cleared at start. It grows by xfer_words per handed-off descriptor when cnt_type is 0, and by 1 when cnt_type is 1.
- R8: busy rises the cycle after an accepted start. It falls once elem_count ids have been taken and no descriptor is pending. done then equals set_done, and done is cleared by the next accepted start.
- R9: With dst_circ and dst_post_upd both 1, the destination pointer wraps modulo dst_buf_bytes.
- R10: A filter value written through the filter write port takes effect only at the next accepted start.
- R11: At most one id is taken and one descriptor issued per cycle. A stalled descriptor keeps tx_valid high and both addresses stable.
- R12: A start while busy is ignored. No id is accepted once elem_count ids have been taken.
- R13: After reset, busy, done, tx_valid, id_ready and cmpl_count are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; samples all control fields |
| table_base | input | AW | Table base address |
| list_base | input | AW | Word address of the first id |
| elem_count | input | CW | Number of ids in the list |
| list_type | input | 1 | 0 word offset, 1 row index |
| row_stride | input | 4 | Row stride multiplier |
| ofs_src | input | 1 | 0 static offset, 1 circular window |
| ofs_static | input | AW | Static offset operand |
| win_offset | input | WW | Window start position |
| win_size | input | WW | Window size |
| win_post_upd | input | 1 | Step window per id |
| dst_base | input | AW | Destination tile base |
| dst_stride_code | input | 3 | Destination step code (7 = no step) |
| dst_circ | input | 1 | Destination is a circular buffer |
| dst_post_upd | input | 1 | Destination pointer wraps when circular |
| dst_buf_bytes | input | AW | Circular destination size in bytes |
| filt_en | input | 1 | Id filter enable |
| filt_mode | input | 1 | 0 skip (gap), 1 compact |
| filt_wr | input | 1 | Filter value write strobe |
| filt_wdata | input | IDW | Filter value |
| cnt_type | input | 1 | 0 count words, 1 count descriptors |
| xfer_words | input | WDW | 4-byte words per descriptor |
| set_done | input | 1 | Raise done at completion |
| id_valid | input | 1 | Id stream valid |
| id_data | input | IDW | Id value |
| id_ready | output | 1 | Id stream ready |
| id_addr | output | AW | Word address of the id being requested |
| tx_valid | output | 1 | Descriptor valid |
| tx_ready | input | 1 | Descriptor ready |
| tx_src_addr | output | AW | Table address |
| tx_dst_addr | output | AW | Tile address |
| cmpl_count | output | CW+WDW | Completion counter |
| busy | output | 1 | List in progress |
| done | output | 1 | Done flag |

## Verification
A behavioural reference builds the expected descriptor sequence for each job. That sequence is compared against every handshake, under both an always-ready consumer and a consumer that stalls every other cycle. Jobs use word mode with a static offset and then row mode with stride 13, which tells the raw and scaled address paths apart. Skip and compact filtering are run on id lists with repeated matching values, so the destination gap and its absence can be told apart. One job rewrites the filter and pulses start mid-list, which separates the latched filter value from the register value. Further jobs cover a three-entry window with a nonzero start and a no-step code, a 384-byte circular destination with 128-byte steps, an empty list, and a list with done disabled. Each job also offers one id too many to show the list boundary.

// File: rtl/idx_agu_pkg.sv
package idx_agu_pkg;

  typedef enum logic {LIST_WORD = 1'b0, LIST_ROW = 1'b1} list_kind_e;
  typedef enum logic {FILT_SKIP = 1'b0, FILT_PACK = 1'b1} filt_kind_e;
  typedef enum logic {OFS_STATIC = 1'b0, OFS_WINDOW = 1'b1} ofs_kind_e;
  typedef enum logic {CNT_WORD = 1'b0, CNT_DESC = 1'b1} cnt_kind_e;

  localparam logic [2:0] NO_STEP_CODE = 3'd7;

  // Destination granule in bytes for a 3-bit step code.
  function automatic logic [11:0] step_bytes(input logic [2:0] code);
    if (code == NO_STEP_CODE) return 12'd0;
    return 12'd32 << code;
  endfunction

endpackage

// File: rtl/idx_agu_ring.sv
// Pointer register that steps by a variable amount and optionally wraps.
module idx_agu_ring #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         adv,
  input  logic [W-1:0] step,
  input  logic [W-1:0] limit,
  input  logic         wrap_en,
  output logic [W-1:0] ptr
);

  logic [W:0]   sum;
  logic [W-1:0] ptr_d;
  logic         ptr_en;

  always_comb begin
    sum = {1'b0, ptr} + {1'b0, step};
    if (wrap_en && (sum >= {1'b0, limit})) sum = sum - {1'b0, limit};
    ptr_en = load | adv;
    ptr_d  = load ? load_val : sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (ptr_en) ptr <= ptr_d;
  end

endmodule

// File: rtl/idx_agu_srcgen.sv
// Table address: base + offset + (raw id | id * 4-bit stride).
module idx_agu_srcgen import idx_agu_pkg::*; #(
  parameter int AW  = 32,
  parameter int IDW = 16
) (
  input  logic [AW-1:0]  base,
  input  logic [AW-1:0]  offset,
  input  logic [IDW-1:0] id,
  input  logic           list_type,
  input  logic [3:0]     stride,
  output logic [AW-1:0]  addr
);

  logic [AW-1:0] id_ext;
  logic [AW-1:0] stride_ext;
  logic [AW-1:0] scaled;

  always_comb begin
    id_ext     = AW'(id);
    stride_ext = AW'(stride);
    scaled     = id_ext * stride_ext;
    addr       = base + offset + ((list_type == LIST_ROW) ? scaled : id_ext);
  end

endmodule

// File: rtl/idx_stream_agu.sv
module idx_stream_agu import idx_agu_pkg::*; #(
  parameter  int AW  = 32,
  parameter  int IDW = 16,
  parameter  int CW  = 12,
  parameter  int WW  = 10,
  parameter  int WDW = 8,
  localparam int CCW = CW + WDW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW-1:0]  table_base,
  input  logic [AW-1:0]  list_base,
  input  logic [CW-1:0]  elem_count,
  input  logic           list_type,
  input  logic [3:0]     row_stride,
  input  logic           ofs_src,
  input  logic [AW-1:0]  ofs_static,
  input  logic [WW-1:0]  win_offset,
  input  logic [WW-1:0]  win_size,
  input  logic           win_post_upd,
  input  logic [AW-1:0]  dst_base,
  input  logic [2:0]     dst_stride_code,
  input  logic           dst_circ,
  input  logic           dst_post_upd,
  input  logic [AW-1:0]  dst_buf_bytes,
  input  logic           filt_en,
  input  logic           filt_mode,
  input  logic           filt_wr,
  input  logic [IDW-1:0] filt_wdata,
  input  logic           cnt_type,
  input  logic [WDW-1:0] xfer_words,
  input  logic           set_done,
  input  logic           id_valid,
  input  logic [IDW-1:0] id_data,
  output logic           id_ready,
  output logic [AW-1:0]  id_addr,
  output logic           tx_valid,
  input  logic           tx_ready,
  output logic [AW-1:0]  tx_src_addr,
  output logic [AW-1:0]  tx_dst_addr,
  output logic [CCW-1:0] cmpl_count,
  output logic           busy,
  output logic           done
);

  // Job fields captured at start
  logic [AW-1:0]  tb_q, lb_q, ostat_q, db_q, dbuf_q;
  logic           lt_q, osrc_q, wupd_q, dcirc_q, dupd_q;
  logic           fen_q, fmode_q, ct_q, sdone_q;
  logic [3:0]     stride_q;
  logic [2:0]     code_q;
  logic [WW-1:0]  wsize_q;
  logic [WDW-1:0] words_q;
  logic [IDW-1:0] filt_reg_q, filt_act_q;

  // Run state
  logic           busy_q, busy_d, done_q, done_d;
  logic [CW-1:0]  remain_q, remain_d, idx_q, idx_d;
  logic           txv_q, txv_d;
  logic [AW-1:0]  src_q, dstq_q;
  logic [CCW-1:0] cmpl_q, cmpl_d;
  logic           cmpl_en;

  // Datapath wires
  logic           start_acc, id_fire, hit, emit, dst_adv, win_adv, finish, tx_load;
  logic [WW-1:0]  win_ptr;
  logic [AW-1:0]  dst_ptr, dst_step, cur_ofs, src_addr;

  assign start_acc = start & ~busy_q;

  always_comb begin
    id_ready = busy_q & (remain_q != '0) & (~txv_q | tx_ready);
    id_fire  = id_valid & id_ready;
    hit      = fen_q & (id_data == filt_act_q);
    emit     = id_fire & ~hit;
    dst_adv  = id_fire & ~(hit & (fmode_q == FILT_PACK));
    win_adv  = id_fire & (osrc_q == OFS_WINDOW) & wupd_q;
    cur_ofs  = (osrc_q == OFS_WINDOW) ? AW'(win_ptr) : ostat_q;
    dst_step = AW'(step_bytes(code_q));
    finish   = busy_q & (remain_q == '0) & ~txv_q;
    tx_load  = emit;
  end

  // Filter value register: written any time, copied into use at start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       filt_reg_q <= '0;
    else if (filt_wr) filt_reg_q <= filt_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_q <= '0; lb_q <= '0; ostat_q <= '0; db_q <= '0; dbuf_q <= '0;
      lt_q <= 1'b0; osrc_q <= 1'b0; wupd_q <= 1'b0; dcirc_q <= 1'b0; dupd_q <= 1'b0;
      fen_q <= 1'b0; fmode_q <= 1'b0; ct_q <= 1'b0; sdone_q <= 1'b0;
      stride_q <= '0; code_q <= '0; wsize_q <= '0; words_q <= '0; filt_act_q <= '0;
    end else if (start_acc) begin
      tb_q <= table_base; lb_q <= list_base; ostat_q <= ofs_static;
      db_q <= dst_base; dbuf_q <= dst_buf_bytes;
      lt_q <= list_type; osrc_q <= ofs_src; wupd_q <= win_post_upd;
      dcirc_q <= dst_circ; dupd_q <= dst_post_upd;
      fen_q <= filt_en; fmode_q <= filt_mode; ct_q <= cnt_type; sdone_q <= set_done;
      stride_q <= row_stride; code_q <= dst_stride_code; wsize_q <= win_size;
      words_q <= xfer_words; filt_act_q <= filt_reg_q;
    end
  end

  idx_agu_ring #(.W(WW)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_acc),
    .load_val (win_offset),
    .adv      (win_adv),
    .step     (WW'(1)),
    .limit    (wsize_q),
    .wrap_en  (1'b1),
    .ptr      (win_ptr)
  );

  idx_agu_ring #(.W(AW)) u_dst (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_acc),
    .load_val ('0),
    .adv      (dst_adv),
    .step     (dst_step),
    .limit    (dbuf_q),
    .wrap_en  (dcirc_q & dupd_q),
    .ptr      (dst_ptr)
  );

  idx_agu_srcgen #(.AW(AW), .IDW(IDW)) u_src (
    .base      (tb_q),
    .offset    (cur_ofs),
    .id        (id_data),
    .list_type (lt_q),
    .stride    (stride_q),
    .addr      (src_addr)
  );

  // Next state
  always_comb begin
    busy_d   = start_acc | (busy_q & ~finish);
    done_d   = start_acc ? 1'b0 : (finish ? sdone_q : done_q);
    remain_d = start_acc ? elem_count : (id_fire ? remain_q - 1'b1 : remain_q);
    idx_d    = start_acc ? '0 : (id_fire ? idx_q + 1'b1 : idx_q);
    txv_d    = tx_load | (txv_q & ~tx_ready);
    cmpl_en  = start_acc | (txv_q & tx_ready);
    cmpl_d   = start_acc ? '0
             : cmpl_q + ((ct_q == CNT_DESC) ? CCW'(1) : CCW'(words_q));
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      remain_q <= '0;
      idx_q    <= '0;
      txv_q    <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      done_q   <= done_d;
      remain_q <= remain_d;
      idx_q    <= idx_d;
      txv_q    <= txv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cmpl_q <= '0;
    else if (cmpl_en) cmpl_q <= cmpl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dstq_q <= '0;
    end else if (tx_load) begin
      src_q  <= src_addr;
      dstq_q <= db_q + dst_ptr;
    end
  end

  assign id_addr     = lb_q + AW'(idx_q);
  assign tx_valid    = txv_q;
  assign tx_src_addr = src_q;
  assign tx_dst_addr = dstq_q;
  assign cmpl_count  = cmpl_q;
  assign busy        = busy_q;
  assign done        = done_q;

endmodule

// File: rtl/idx_stream_agu_chk.sv
module idx_stream_agu_chk #(
  parameter int AW  = 32,
  parameter int CCW = 20
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           id_ready,
  input logic           tx_valid,
  input logic           tx_ready,
  input logic [AW-1:0]  tx_src_addr,
  input logic [AW-1:0]  tx_dst_addr,
  input logic [CCW-1:0] cmpl_count
);

  // R11
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_src_addr) && $stable(tx_dst_addr)));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!id_ready && !tx_valid));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  cmpl_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cmpl_count >= $past(cmpl_count)));

  // R13
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done && !tx_valid && cmpl_count == '0));

endmodule

bind idx_stream_agu idx_stream_agu_chk #(.AW(AW), .CCW(CCW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .id_ready    (id_ready),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .tx_src_addr (tx_src_addr),
  .tx_dst_addr (tx_dst_addr),
  .cmpl_count  (cmpl_count)
);

// File: tb/idx_stream_agu_bench.sv
module idx_stream_agu_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, list_type, ofs_src, win_post_upd, dst_circ, dst_post_upd;
  logic        filt_en, filt_mode, filt_wr, cnt_type, set_done, id_valid, tx_ready;
  logic [31:0] table_base, list_base, ofs_static, dst_base, dst_buf_bytes;
  logic [11:0] elem_count;
  logic [3:0]  row_stride;
  logic [9:0]  win_offset, win_size;
  logic [2:0]  dst_stride_code;
  logic [15:0] filt_wdata, id_data;
  logic [7:0]  xfer_words;
  logic        id_ready, tx_valid, busy, done;
  logic [31:0] id_addr, tx_src_addr, tx_dst_addr;
  logic [19:0] cmpl_count;

  idx_stream_agu u_idx_stream_agu (.*);

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_src[$];
  logic [31:0] exp_dst[$];
  string       cur_req = "R13";
  bit          rdy_alt = 1'b0;
  int          cyc = 0;
  int          ids[0:15];
  logic [15:0] filt_model = '0;
  logic        prev_stall = 1'b0;
  logic [31:0] prev_src, prev_dst;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Consumer side: ready pattern and per-handshake comparison
  always @(negedge clk) begin
    cyc++;
    tx_ready = rdy_alt ? cyc[0] : 1'b1;
    #2;
    if (rst_n) begin
      if (prev_stall)
        chk(tx_valid && tx_src_addr == prev_src && tx_dst_addr == prev_dst, "R11 hold",
            {tx_src_addr, tx_dst_addr}, {prev_src, prev_dst});
      prev_stall = tx_valid && !tx_ready;
      prev_src   = tx_src_addr;
      prev_dst   = tx_dst_addr;
      if (tx_valid && tx_ready) begin
        if (exp_src.size() == 0) chk(1'b0, {cur_req, " extra descriptor"}, tx_src_addr, 0);
        else begin
          logic [31:0] es, ed;
          es = exp_src.pop_front();
          ed = exp_dst.pop_front();
          chk(tx_src_addr == es, {cur_req, " src"}, tx_src_addr, es);
          chk(tx_dst_addr == ed, {cur_req, " dst"}, tx_dst_addr, ed);
        end
      end
    end
  end

  // Runs one list; the reference builds the expected descriptors first.
  task automatic run_job(input int n, input string req, input bit poke);
    logic [31:0] wp, dp, ofs, a, exp_cmpl;
    bit          hit;
    exp_cmpl = 0;
    wp = 32'(win_offset);
    dp = 0;
    for (int i = 0; i < n; i++) begin
      hit = filt_en && (16'(ids[i]) == filt_model);
      ofs = ofs_src ? wp : ofs_static;
      a   = table_base + ofs + (list_type ? 32'(ids[i]) * 32'(row_stride) : 32'(ids[i]));
      if (!hit) begin
        exp_src.push_back(a);
        exp_dst.push_back(dst_base + dp);
        exp_cmpl += cnt_type ? 1 : 32'(xfer_words);
      end
      if (ofs_src && win_post_upd) wp = (wp + 1) % 32'(win_size);
      if (!(hit && filt_mode)) begin
        dp = dp + ((dst_stride_code == 3'd7) ? 0 : (32 << dst_stride_code));
        if (dst_circ && dst_post_upd) dp = dp % dst_buf_bytes;
      end
    end
    cur_req = req;
    elem_count = 12'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(busy == 1'b1 && done == 1'b0, "R8 busy after start, done cleared", {busy, done}, 2'b10);
    #1;
    for (int i = 0; i < n; i++) begin
      id_data  = 16'(ids[i]);
      id_valid = 1'b1;
      if (poke && i == 2) begin
        start = 1'b1; table_base = table_base + 32'h40000;
        filt_wr = 1'b1; filt_wdata = 16'd3;
      end
      forever begin
        #2;
        if (id_ready) begin
          chk(id_addr == list_base + 32'(i), "R12 id address", id_addr, list_base + 32'(i));
          break;
        end
        @(negedge clk);
        start = 1'b0; filt_wr = 1'b0;
      end
      @(negedge clk);
      start = 1'b0; filt_wr = 1'b0;
    end
    id_data = 16'(ids[n]);
    id_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #2;
      chk(!id_ready, "R12 no id beyond count", id_ready, 0);
      @(negedge clk);
    end
    id_valid = 1'b0;
    while (busy) @(negedge clk);
    #2;
    chk(done == set_done, "R8 done flag", done, set_done);
    chk(cmpl_count == 20'(exp_cmpl), {"R7 completion count ", req}, cmpl_count, exp_cmpl);
    chk(exp_src.size() == 0, {req, " all descriptors issued"}, exp_src.size(), 0);
    exp_src.delete();
    exp_dst.delete();
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 0; list_type = 0; ofs_src = 0; win_post_upd = 0;
    dst_circ = 0; dst_post_upd = 0; filt_en = 0; filt_mode = 0; filt_wr = 0;
    cnt_type = 0; set_done = 1; id_valid = 0; id_data = 0; filt_wdata = 0;
    table_base = 32'h1000; list_base = 32'h20_0000; ofs_static = 32'h100;
    dst_base = 32'h8000_0000; dst_buf_bytes = 32'd4096; elem_count = 0;
    row_stride = 0; win_offset = 0; win_size = 1; dst_stride_code = 0; xfer_words = 4;
    repeat (3) @(negedge clk);
    #2;
    // R13 reset state
    chk(!busy && !done && !tx_valid && !id_ready && cmpl_count == 0, "R13 reset state",
        {busy, done, tx_valid, id_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 word offset, R3 32-byte step, R7 word counting
    ids = '{5, 9, 0, 77, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    run_job(4, "R1", 0);

    // R2 row offset stride 13, R3 256-byte step, R7 descriptor counting, R11 stalls
    list_type = 1; row_stride = 4'd13; dst_stride_code = 3'd3; cnt_type = 1; rdy_alt = 1;
    ids = '{0, 1, 2, 100, 65535, 7, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    run_job(5, "R2", 0);

    // R4 skip leaves a gap in the destination
    list_type = 0; dst_stride_code = 3'd1; cnt_type = 0; rdy_alt = 0;
    filt_en = 1; filt_mode = 0;
    @(negedge clk); filt_wdata = 16'd9; filt_wr = 1; @(negedge clk); filt_wr = 0;
    filt_model = 16'd9;
    ids = '{9, 3, 9, 4, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    run_job(4, "R4", 0);

    // R5 compact; R10 filter write and R12 start during busy both ignored for this list
    filt_mode = 1;
    @(negedge clk); filt_wdata = 16'd4; filt_wr = 1; @(negedge clk); filt_wr = 0;
    filt_model = 16'd4;
    ids = '{3, 4, 4, 6, 3, 8, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    run_job(5, "R5 R12 R10", 1);

    // R10 the value written mid-list (3) applies from this start
    table_base = 32'h1000;
    filt_model = 16'd3;
    ids = '{3, 4, 3, 5, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    run_job(4, "R10", 0);

    // R6 circular window offset, R3 code 7 keeps the destination fixed
    filt_en = 0; ofs_src = 1; win_offset = 10'd2; win_size = 10'd3; win_post_upd = 1;
    dst_stride_code = 3'd7;
    ids = '{10, 10, 10, 10, 10, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    run_job(5, "R6 R3", 0);

    // R9 circular destination wraps at 384 bytes with 128-byte steps
    ofs_src = 0; dst_stride_code = 3'd2; dst_circ = 1; dst_post_upd = 1;
    dst_buf_bytes = 32'd384; rdy_alt = 1;
    ids = '{1, 2, 3, 4, 5, 6, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    run_job(5, "R9", 0);

    // R8 empty list completes; then done stays low when not requested
    rdy_alt = 0; dst_circ = 0;
    run_job(0, "R8 empty", 0);
    set_done = 0;
    ids = '{11, 12, 13, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    run_job(2, "R8 no done", 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule